// File: doc/BRIEF.md
# Programmable Serial Input Sampling Aligner

This block retimes a single serial TDM input line. It runs on a local clock at four times the bit rate, so each bit cell lasts four fast cycles and one fast cycle is a quarter of a bit period. The incoming line goes through a tapped delay line. A registered tap index picks the quarter-bit instant whose value becomes the recovered bit. A local frame pulse fixes the bit-cell phase. From that phase the block raises a one-cycle bit strobe in every cell and updates the recovered bit at the same time.

A 5-bit delay code and a mode select set the tap index. In linear mode the code is a plain count of quarter-bit delay steps. In split mode the upper three code bits give a whole-bit delay. The lower two bits give the sampling phase, and those two bits are not in monotonic order. The code and mode are taken in only at a frame pulse, so the tap never moves in the middle of a frame.

Top module: `sampling_aligner`

## Requirements
- R1: While reset is asserted, and after reset until the first frame pulse, `strobe_o` and `bit_o` are 0.
- R2: If the frame pulse is high in the cycle ending at clock edge F, `strobe_o` is high for exactly one cycle after each edge F+3, F+7, F+11, ... and low after every other edge. A later frame pulse restarts this count.
- R3: `bit_o` changes only in cycles where `strobe_o` is high. It holds its value otherwise.
- R4: In linear mode (`mode_i`=0), the tap index is n = 3 + code. When `strobe_o` goes high after capture edge e, `bit_o` equals the `data_i` value sampled at edge e-n. For example, code 19 gives n = 22.
- R5: In split mode (`mode_i`=1), n = 4*code[4:2] + p. Here p is 3 for code[1:0]=00, 4 for 01, 1 for 10 and 2 for 11. `bit_o` follows the same relation as in R4.
- R6: Code 0 gives n = 3 in both modes.
- R7: `code_i` and `mode_i` are loaded only at an edge where `frame_i` is high. Changes at other times have no effect on `bit_o` until the next frame pulse. After reset the loaded configuration is linear mode with code 0.
- R8: The delay line covers the largest index, n = 34 (linear mode, code 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse, marks the first quarter of a bit cell |
| data_i | input | 1 | Serial input line |
| mode_i | input | 1 | 0 = linear delay, 1 = split bit delay plus phase |
| code_i | input | 5 | Delay code |
| bit_o | output | 1 | Recovered bit |
| strobe_o | output | 1 | One-cycle strobe marking a new `bit_o` |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a frame and must be ignored, because its effect would show only as a wrong tap on later strobes. In every run the bench loads a code at a frame pulse. Sixty cycles later it drives a different code and mode without a frame pulse, then keeps comparing each recovered bit against the index of the original code. The runs cover both modes with all 32 codes each, plus a table of hand-computed indices that includes the non-monotonic phase order and the deepest tap.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int CODE_W   = 5;
  localparam int LINE_LEN = (2 ** CODE_W) + 4;
  localparam int IDX_W    = $clog2(LINE_LEN);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // split mode phase order: 00->3, 01->4, 10->1, 11->2
  function automatic idx_t tap_index(input logic split, input code_t code);
    idx_t ph;
    idx_t whole;
    if (!split) begin
      return idx_t'(code) + idx_t'(3);
    end
    unique case (code[1:0])
      2'b00:   ph = idx_t'(3);
      2'b01:   ph = idx_t'(4);
      2'b10:   ph = idx_t'(1);
      default: ph = idx_t'(2);
    endcase
    whole = idx_t'(code[CODE_W-1:2]);
    return (whole << 2) + ph;
  endfunction
endpackage

// File: rtl/sa_phase_ctr.sv
module sa_phase_ctr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic cap_o
);
  logic [1:0] ph_q;
  logic       run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else if (frame_i) begin
      ph_q  <= 2'd1;
      run_q <= 1'b1;
    end else if (run_q) begin
      ph_q  <= ph_q + 2'd1;
    end
  end

  // last quarter of a cell; frame cycle is always quarter 0
  assign cap_o = run_q && !frame_i && (ph_q == 2'd3);
endmodule

// File: rtl/sa_cfg_reg.sv
module sa_cfg_reg
  import sa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_i,
  input  logic  mode_i,
  input  code_t code_i,
  output idx_t  idx_o
);
  idx_t idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= tap_index(1'b0, '0);
    else if (frame_i) idx_q <= tap_index(mode_i, code_i);
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/sa_tap_line.sv
module sa_tap_line
  import sa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  idx_t sel_i,
  output logic tap_o
);
  localparam int SR_LEN = LINE_LEN - 1;

  logic [SR_LEN-1:0]   sr_q;
  logic [LINE_LEN-1:0] line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_LEN-2:0], data_i};
  end

  // line[k] is data_i from k edges back
  assign line = {sr_q, data_i};

  always_comb begin
    tap_o = 1'b0;
    for (int i = 0; i < LINE_LEN; i++) begin
      if (sel_i == idx_t'(i)) tap_o = line[i];
    end
  end
endmodule

// File: rtl/sampling_aligner.sv
module sampling_aligner
  import sa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             data_i,
  input  logic             mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic             bit_o,
  output logic             strobe_o
);
  logic cap;
  logic tap;
  idx_t tap_idx;
  logic bit_q;
  logic strobe_q;

  sa_phase_ctr u_ph (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .cap_o  (cap)
  );

  sa_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .mode_i (mode_i),
    .code_i (code_i),
    .idx_o  (tap_idx)
  );

  sa_tap_line u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .sel_i (tap_idx),
    .tap_o (tap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= cap;
      if (cap) bit_q <= tap;
    end
  end

  assign bit_o    = bit_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/sa_chk.sv
module sa_chk
  import sa_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic frame_i,
  input logic strobe_o,
  input logic bit_o,
  input idx_t tap_idx_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (frame_i) seen_q <= 1'b1;
  end

  // R1
  no_early_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !strobe_o);

  // R2
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  // R2
  strobe_after_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i ##1 !frame_i ##1 !frame_i ##1 !frame_i |=> strobe_o);

  // R3
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(bit_o));

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(tap_idx_i));
endmodule

bind sampling_aligner sa_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_i  (frame_i),
  .strobe_o (strobe_o),
  .bit_o    (bit_o),
  .tap_idx_i(tap_idx)
);

// File: tb/sampling_aligner_test.sv
module sampling_aligner_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       data_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [4:0] code_i = '0;
  logic       bit_o;
  logic       strobe_o;

  int total = 0;
  int bad = 0;
  int k = 0;
  logic       ring [64];
  logic [6:0] lfsr = 7'h5b;

  // {mode, code, alt_mode, alt_code, expected index}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 5'd0,  1'b1, 5'd31, 6'd3},   // R6 linear
    {1'b0, 5'd19, 1'b0, 5'd2,  6'd22},  // R4
    {1'b0, 5'd31, 1'b0, 5'd0,  6'd34},  // R8
    {1'b0, 5'd4,  1'b1, 5'd9,  6'd7},   // R4
    {1'b1, 5'd0,  1'b0, 5'd17, 6'd3},   // R6 split
    {1'b1, 5'd1,  1'b1, 5'd20, 6'd4},   // R5
    {1'b1, 5'd2,  1'b0, 5'd31, 6'd1},   // R5
    {1'b1, 5'd3,  1'b1, 5'd0,  6'd2},   // R5
    {1'b1, 5'd29, 1'b0, 5'd5,  6'd32},  // R5
    {1'b1, 5'd22, 1'b1, 5'd12, 6'd21}   // R5
  };

  sampling_aligner uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .data_i(data_i),
    .mode_i(mode_i), .code_i(code_i), .bit_o(bit_o), .strobe_o(strobe_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic int exp_idx(input logic m, input logic [4:0] c);
    int p;
    if (!m) return 3 + int'(c);
    case (c[1:0])
      2'b00: p = 3;
      2'b01: p = 4;
      2'b10: p = 1;
      default: p = 2;
    endcase
    return 4 * int'(c[4:2]) + p;
  endfunction

  function automatic string tag_of(input logic m, input logic [4:0] c);
    if (c == 0) return "R6";
    if (m) return "R5";
    if (c == 31) return "R8";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive next data bit for the coming edge, recording it
  task automatic drive_data(input bit step);
    if (step) lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    data_i = lfsr[0];
    ring[k % 64] = data_i;
    k++;
  endtask

  // no frame pulse: strobe must stay low and bit_o at zero (R1)
  task automatic idle_check(input int n);
    int sbad = 0;
    int bval = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (strobe_o !== 1'b0) sbad++;
      if (bit_o !== 1'b0) bval++;
      frame_i = 1'b0;
      drive_data(i % 3 == 0);
    end
    check(sbad == 0, "R1 strobe before frame", sbad, 0);
    check(bval == 0, "R1 bit before frame", bval, 0);
  endtask

  task automatic run_cfg(input logic m, input logic [4:0] c, input logic am,
                         input logic [4:0] ac, input int n_exp, input string tag);
    int f;
    int sbad = 0, bbad = 0, hbad = 0;
    int s_act = 0, s_exp = 0, b_act = 0, b_exp = 0;
    logic prev_bit;
    @(negedge clk_i);
    mode_i = m; code_i = c; frame_i = 1'b1;
    f = k;
    prev_bit = bit_o;
    drive_data(1'b1);
    for (int cyc = 0; cyc < 124; cyc++) begin
      int  e;
      bit  s_want;
      @(negedge clk_i);
      e = k - 1;
      s_want = (e >= f + 3) && ((e - f) % 4 == 3);
      // R2 strobe timing
      if (strobe_o !== s_want) begin
        if (sbad == 0) begin s_act = int'(strobe_o); s_exp = int'(s_want); end
        sbad++;
      end
      // R3 hold between strobes
      if (!strobe_o && bit_o !== prev_bit) hbad++;
      // R4/R5/R7 recovered bit against original index
      if (strobe_o && (e - f >= 40)) begin
        if (bit_o !== ring[(e - n_exp) % 64]) begin
          if (bbad == 0) begin b_act = int'(bit_o); b_exp = int'(ring[(e - n_exp) % 64]); end
          bbad++;
        end
      end
      prev_bit = bit_o;
      frame_i = 1'b0;
      if (cyc == 60) begin mode_i = am; code_i = ac; end  // R7 mid-frame change
      drive_data((k - f) % 4 == 0);
    end
    check(sbad == 0, "R2 strobe pattern", s_act, s_exp);
    check(hbad == 0, "R3 bit hold", hbad, 0);
    check(bbad == 0, {tag, " R7 recovered bit"}, b_act, b_exp);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(strobe_o === 1'b0, "R1 reset strobe", int'(strobe_o), 0);
    check(bit_o === 1'b0, "R1 reset bit", int'(bit_o), 0);
    rst_ni = 1'b1;
    idle_check(14);

    // table of hand-computed indices
    for (int v = 0; v < 10; v++) begin
      run_cfg(VEC[v][17], VEC[v][16:12], VEC[v][11], VEC[v][10:6],
              int'(VEC[v][5:0]), tag_of(VEC[v][17], VEC[v][16:12]));
    end

    // sweep of every code in both modes, mid-frame change to another code
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 32; c++) begin
        run_cfg(m[0], 5'(c), ~m[0], 5'(c + 11), exp_idx(m[0], 5'(c)), tag_of(m[0], 5'(c)));
      end
    end

    // R1 reset in the middle of traffic
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(strobe_o === 1'b0, "R1 mid reset strobe", int'(strobe_o), 0);
    check(bit_o === 1'b0, "R1 mid reset bit", int'(bit_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_check(10);
    run_cfg(1'b1, 5'd31, 1'b0, 5'd8, 30, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule